// File: doc/BRIEF.md
# Descriptor Condition Evaluator

This unit sits beside a descriptor-processing sequencer and makes three yes/no decisions for the descriptor being executed: whether the channel stalls on a wait, whether it takes a branch to an alternate descriptor, and whether it signals an interrupt. Each decision comes from a 2-bit gate code taken from the command word. The code either fixes the answer (never or always) or makes it follow a condition. That condition is a masked compare of the low device-status bits against a per-decision select register.

There are three copies of the compare-and-gate logic, one per decision, and all of them read the same device-status byte. The wait decision is combinational and is qualified by the sequencer's pending indication, so a stall appears in the same cycle as its inputs. The interrupt and branch decisions are registered on the sequencer's completion strobe. The interrupt is a one-cycle pulse, and the branch flag holds its value until the next completion.

Top module: `cond_eval`

## Requirements
- R1: The 6-bit `cmd_ctl` input holds three gate codes: bits 1:0 control the wait, bits 3:2 control the branch, and bits 5:4 control the interrupt.
- R2: Gate code 0 yields false and gate code 3 yields true, whatever the status and the select register hold.
- R3: A select register carries a 4-bit mask in bits 19:16 and a 4-bit match value in bits 3:0. The condition is true when (status[3:0] & mask) equals (value & mask). Gate code 1 yields the condition and gate code 2 yields its inverse.
- R4: Device-status bits 7:4 and all unused select-register bits have no effect on any decision.
- R5: When the mask is zero, the condition is true, so code 1 yields true and code 2 yields false.
- R6: `irq_pulse` is high for exactly the one cycle that follows a rising clock edge at which `done_strobe` was high and the interrupt decision was true. It is low in every other cycle.
- R7: `branch_taken` takes the branch decision at each rising edge where `done_strobe` is high and holds its value at all other edges.
- R8: `wait_stall` equals `cmd_pending` ANDed with the wait decision, in the same cycle and with no register delay.
- R9: While `rst_n` is low, `irq_pulse` and `branch_taken` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_ctl | input | 6 | Gate codes: interrupt [5:4], branch [3:2], wait [1:0] |
| dev_status | input | 8 | Device status byte; only bits 3:0 are compared |
| irq_sel | input | 32 | Interrupt select: mask [19:16], value [3:0] |
| br_sel | input | 32 | Branch select: mask [19:16], value [3:0] |
| wait_sel | input | 32 | Wait select: mask [19:16], value [3:0] |
| cmd_pending | input | 1 | A command is being executed |
| done_strobe | input | 1 | Completion strobe from the sequencer |
| irq_pulse | output | 1 | One-cycle interrupt request |
| branch_taken | output | 1 | Branch decision of the last completion |
| wait_stall | output | 1 | Stall request for the current command |

## Verification
The assertions check on every cycle that an interrupt pulse always follows a completion strobe, that the branch flag never moves without a strobe, and that no stall appears without a pending command. They also check that the fixed never and always codes and a zero mask force the expected result. Only the bench scenarios can show that the right bits of the command word reach the right decision, that the masked compare gives the correct answer for particular status and value patterns, and that the upper status bits and stray select bits are really ignored.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;
    typedef enum logic [1:0] {
        GATE_NEVER  = 2'd0,
        GATE_IF_HIT = 2'd1,
        GATE_IF_MISS = 2'd2,
        GATE_ALWAYS = 2'd3
    } gate_e;

    localparam int N_DEC   = 3;
    localparam int DEC_WAIT = 0;
    localparam int DEC_BR   = 1;
    localparam int DEC_IRQ  = 2;

    typedef struct packed {
        logic irq;
        logic branch;
    } dec_state_t;
endpackage

// File: rtl/cond_cmp.sv
module cond_cmp #(
    parameter int STAT_W = 4
) (
    input  logic [STAT_W-1:0] status,
    input  logic [STAT_W-1:0] mask,
    input  logic [STAT_W-1:0] value,
    output logic              match
);
    always_comb begin
        match = ((status & mask) == (value & mask));
    end
endmodule

// File: rtl/cond_gate.sv
module cond_gate
    import cond_eval_pkg::*;
(
    input  logic [1:0] code,
    input  logic       match,
    output logic       hit
);
    always_comb begin
        unique case (gate_e'(code))
            GATE_NEVER:   hit = 1'b0;
            GATE_IF_HIT:  hit = match;
            GATE_IF_MISS: hit = ~match;
            default:      hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/cond_eval.sv
module cond_eval
    import cond_eval_pkg::*;
#(
    parameter int DEV_W    = 8,
    parameter int STAT_W   = 4,
    parameter int SEL_W    = 32,
    parameter int MASK_LSB = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2*N_DEC-1:0]       cmd_ctl,
    input  logic [DEV_W-1:0]         dev_status,
    input  logic [SEL_W-1:0]         irq_sel,
    input  logic [SEL_W-1:0]         br_sel,
    input  logic [SEL_W-1:0]         wait_sel,
    input  logic                     cmd_pending,
    input  logic                     done_strobe,
    output logic                     irq_pulse,
    output logic                     branch_taken,
    output logic                     wait_stall
);
    localparam int MASK_MSB = MASK_LSB + STAT_W - 1;

    logic [SEL_W-1:0]  sel_arr [N_DEC];
    logic [N_DEC-1:0]  match;
    logic [N_DEC-1:0]  hit;
    dec_state_t        state_d, state_q;

    assign sel_arr[DEC_WAIT] = wait_sel;
    assign sel_arr[DEC_BR]   = br_sel;
    assign sel_arr[DEC_IRQ]  = irq_sel;

    for (genvar g = 0; g < N_DEC; g++) begin : g_dec
        cond_cmp #(.STAT_W(STAT_W)) u_cmp (
            .status (dev_status[STAT_W-1:0]),
            .mask   (sel_arr[g][MASK_MSB:MASK_LSB]),
            .value  (sel_arr[g][STAT_W-1:0]),
            .match  (match[g])
        );
        cond_gate u_gate (
            .code  (cmd_ctl[2*g +: 2]),
            .match (match[g]),
            .hit   (hit[g])
        );
    end

    logic unused_bits;
    assign unused_bits = ^{dev_status[DEV_W-1:STAT_W],
                           irq_sel[SEL_W-1:MASK_MSB+1], irq_sel[MASK_LSB-1:STAT_W],
                           br_sel[SEL_W-1:MASK_MSB+1],  br_sel[MASK_LSB-1:STAT_W],
                           wait_sel[SEL_W-1:MASK_MSB+1], wait_sel[MASK_LSB-1:STAT_W]};

    always_comb begin
        state_d     = state_q;
        state_d.irq = done_strobe & hit[DEC_IRQ];
        if (done_strobe) begin
            state_d.branch = hit[DEC_BR];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign irq_pulse    = state_q.irq;
    assign branch_taken = state_q.branch;
    assign wait_stall   = cmd_pending & hit[DEC_WAIT];

    // R6
    irq_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(done_strobe));

    // R7
    branch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_strobe |=> $stable(branch_taken));

    // R8
    wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_pending |-> !wait_stall);

    // R2
    irq_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_strobe && cmd_ctl[5:4] == 2'd0) |=> !irq_pulse);

    // R2
    branch_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_strobe && cmd_ctl[3:2] == 2'd3) |=> branch_taken);

    // R5
    irq_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_strobe && cmd_ctl[5:4] == 2'd1 && irq_sel[MASK_MSB:MASK_LSB] == '0)
        |=> irq_pulse);
endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit    irq;
        bit    br;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cmd_ctl = '0;
    logic [7:0]  dev_status = '0;
    logic [31:0] irq_sel = '0;
    logic [31:0] br_sel = '0;
    logic [31:0] wait_sel = '0;
    logic        cmd_pending = 1'b0;
    logic        done_strobe = 1'b0;
    logic        irq_pulse, branch_taken, wait_stall;

    int    total = 0;
    int    bad = 0;
    bit    last_br = 1'b0;
    bit    mon_on = 1'b0;
    item_t sb_q[$];

    cond_eval i_cond_eval (
        .clk(clk), .rst_n(rst_n), .cmd_ctl(cmd_ctl), .dev_status(dev_status),
        .irq_sel(irq_sel), .br_sel(br_sel), .wait_sel(wait_sel),
        .cmd_pending(cmd_pending), .done_strobe(done_strobe),
        .irq_pulse(irq_pulse), .branch_taken(branch_taken), .wait_stall(wait_stall)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit ref_dec(bit [1:0] code, bit [7:0] st, bit [31:0] sel);
        bit m;
        m = ((st[3:0] & sel[19:16]) == (sel[3:0] & sel[19:16]));
        case (code)
            2'd0: return 1'b0;
            2'd1: return m;
            2'd2: return !m;
            default: return 1'b1;
        endcase
    endfunction

    task automatic check(bit ok, string req, bit act, bit exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic step(bit [5:0] cmd, bit [7:0] st, bit [31:0] isel, bit [31:0] bsel,
                        bit [31:0] wsel, bit pend, bit strobe, string tag);
        item_t it;
        bit    wexp;
        @(negedge clk);
        cmd_ctl = cmd; dev_status = st; irq_sel = isel; br_sel = bsel;
        wait_sel = wsel; cmd_pending = pend; done_strobe = strobe;
        #1;
        wexp = pend && ref_dec(cmd[1:0], st, wsel);
        check(wait_stall === wexp, {tag, " R8 wait"}, wait_stall, wexp);
        if (strobe) begin
            it.irq = ref_dec(cmd[5:4], st, isel);
            it.br  = ref_dec(cmd[3:2], st, bsel);
            it.tag = tag;
            sb_q.push_back(it);
        end
    endtask

    // monitor: compares registered outputs a quarter period after each edge
    initial begin
        bit    s;
        item_t it;
        wait (mon_on);
        forever begin
            @(posedge clk);
            s = done_strobe;
            #(CLK_PERIOD/4);
            if (s && sb_q.size() > 0) begin
                it = sb_q.pop_front();
                check(irq_pulse === it.irq, {it.tag, " R6 irq"}, irq_pulse, it.irq);
                check(branch_taken === it.br, {it.tag, " R7 branch"}, branch_taken, it.br);
                last_br = it.br;
            end else begin
                check(irq_pulse === 1'b0, "R6 irq idle", irq_pulse, 1'b0);
                check(branch_taken === last_br, "R7 branch hold", branch_taken, last_br);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(irq_pulse === 1'b0, "R9 reset irq", irq_pulse, 1'b0);
        check(branch_taken === 1'b0, "R9 reset branch", branch_taken, 1'b0);
        rst_n = 1'b1;
        mon_on = 1'b1;

        // R1: each field alone selects only its own decision
        step(6'b11_00_00, 8'h00, 0, 0, 0, 1, 1, "R1 irq field");
        step(6'b00_11_00, 8'h00, 0, 0, 0, 1, 1, "R1 branch field");
        step(6'b00_00_11, 8'h00, 0, 0, 0, 1, 1, "R1 wait field");
        step(6'b00_00_00, 8'h00, 0, 0, 0, 1, 0, "R1 idle");

        // R2: fixed codes with selects set up to mismatch
        step(6'b11_11_11, 8'h05, 32'h000F_000A, 32'h000F_000A, 32'h000F_000A, 1, 1, "R2 always");
        step(6'b00_00_00, 8'h05, 32'h000F_0005, 32'h000F_0005, 32'h000F_0005, 1, 1, "R2 never");

        // R3: masked compare, if-hit and if-miss
        step(6'b01_01_01, 8'h0B, 32'h000A_000A, 32'h000A_000A, 32'h000A_000A, 1, 1, "R3 hit");
        step(6'b01_01_01, 8'h09, 32'h000A_000A, 32'h000A_000A, 32'h000A_000A, 1, 1, "R3 miss");
        step(6'b10_10_10, 8'h09, 32'h000A_000A, 32'h000A_000A, 32'h000A_000A, 1, 1, "R3 inv");
        step(6'b10_01_10, 8'h03, 32'h0003_0003, 32'h0008_0000, 32'h0001_0000, 1, 1, "R3 mixed");

        // R4: upper status bits and stray select bits have no effect
        step(6'b01_01_01, 8'hF6, 32'hFFF6_FFF6, 32'hA5F6_5A56, 32'h00F6_FFF6, 1, 1, "R4 upper");
        step(6'b10_10_10, 8'h96, 32'hFFF6_FFF6, 32'hA5F6_5A56, 32'h00F6_FFF6, 1, 1, "R4 upper inv");

        // R5: zero mask makes the condition true
        step(6'b01_01_01, 8'h0C, 32'hFFF0_FFF3, 32'h0000_0007, 32'h0000_0001, 1, 1, "R5 zero mask");
        step(6'b10_10_10, 8'h0C, 32'h0000_0003, 32'h0000_0007, 32'h0000_0001, 1, 1, "R5 zero inv");

        // R7: branch holds through cycles without strobe
        step(6'b11_11_00, 8'h00, 0, 0, 0, 1, 1, "R7 set");
        step(6'b00_00_00, 8'h00, 0, 0, 0, 0, 0, "R7 no strobe");
        step(6'b00_00_11, 8'h00, 0, 0, 0, 0, 0, "R8 not pending");
        step(6'b00_00_00, 8'h00, 0, 0, 0, 0, 1, "R7 clear");

        // back-to-back strobes
        step(6'b11_00_00, 8'h00, 0, 0, 0, 1, 1, "R6 b2b a");
        step(6'b11_11_00, 8'h00, 0, 0, 0, 1, 1, "R6 b2b b");
        step(6'b00_00_00, 8'h00, 0, 0, 0, 0, 0, "R6 tail");
        repeat (4) @(negedge clk);

        if (sb_q.size() != 0) begin
            bad++; total++;
            $display("FAIL scoreboard: actual=%0d expected=0 items left", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule